// File: doc/BRIEF.md
# Address-Encoded Remote Memory Command Intake

This block sits between the host link and a remote-memory engine. A process starts an operation with one 128-bit posted write into a memory-mapped window. The block builds a complete command from that single write, so two processes posting at the same time can never interleave their commands. The offset of the write inside the window carries the routing and control information: destination node, destination context, source context, privilege flags, notification enables and the operation code. The 128-bit write data carries the operands.

Each write is checked. The block rejects an undefined operation code, nonzero reserved offset bits, and a data-moving transfer that is larger than one 4 KB page or that would run past the end of a page on either side. A rejected write sets a sticky error flag and leaves the queue unchanged. An accepted write goes into one queue that every context shares, and a downstream consumer drains the queue with a valid/ready handshake. Some writes can still be in flight on the link after it has been told to stop. For that reason a stall signal goes high early, as soon as the free slots in the queue drop below that in-flight allowance.

Offset layout with the default parameters (NODE_W=4, CTX_W=3):
- bits 3:0 — reserved.
- bits 6:4 — operation code.
- bits 9:7 — notification enables.
- bits 11:10 — reserved.
- bits 14:12 — privilege flags.
- bits 17:15 — source context.
- bits 20:18 — destination context.
- bits 24:21 — destination node.

Top module: `rma_cmd_ingress`

## Requirements
- R1: The destination node is taken from offset bits [15+2*CTX_W +: NODE_W], the destination context from offset bits [15+CTX_W +: CTX_W], and the source context from offset bits [15 +: CTX_W]. Each appears unchanged on the head of the queue.
- R2: The 9-bit opcode on the queue head is {offset[14:12] flags, offset[9:7] notification enables, offset[6:4] operation code}. The write data appears unchanged as the 128-bit operand.
- R3: Operation code 7 is undefined. Such a write is not queued and sets the error flag. The defined codes are 0 word put, 1 word get, 2 line put, 3 line get, 4 immediate put, 5 notification put and 6 atomic.
- R4: For codes 0 to 3, the length is data[60:48], the source page offset is data[11:0] and the destination page offset is data[75:64]. The write is dropped, and the error flag set, when source offset + length > 4096 or destination offset + length > 4096. Lengths from 0 up to 4096 that stay inside the page are accepted.
- R5: Codes 4 to 6 get no length or page check. They are accepted whatever data[60:48] and the offsets hold.
- R6: Accepted commands leave the queue in arrival order, one entry per accepted write. An entry is popped when cmd_valid and cmd_ready are both high at a clock edge.
- R7: stall is high exactly when the number of queued entries is greater than DEPTH-INFLIGHT.
- R8: A write that arrives while the queue holds DEPTH entries is dropped and sets the error flag.
- R9: After reset the queue is empty, cmd_valid is low, the error flag is low and stall is low.
- R10: Once set, the error flag stays high until reset, even when later writes are accepted.
- R11: A write with any of offset bits [3:0] or [11:10] set is dropped and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One 128-bit posted write this cycle |
| wr_off | input | 15+2*CTX_W+NODE_W | Offset of the write inside the command window |
| wr_data | input | 128 | Write data (operand word) |
| stall | output | 1 | Backpressure toward the host link |
| err_flag | output | 1 | Sticky rejection flag |
| cmd_valid | output | 1 | Queue head holds a command |
| cmd_ready | input | 1 | Consumer takes the head this cycle |
| cmd_op | output | 9 | Opcode of the head command |
| cmd_node | output | NODE_W | Destination node |
| cmd_dctx | output | CTX_W | Destination context |
| cmd_sctx | output | CTX_W | Source context |
| cmd_operand | output | 128 | Operand word |

## Verification
On every cycle, the assertions check the following:
- the error flag never clears once set;
- an undefined operation code always raises the flag;
- a full queue keeps stall high and refuses a write;
- a pop with no push lowers the occupancy by exactly one.

Some behaviours can only be shown by the bench's scenarios:
- correct placement of every offset field, which is swept across all node and context values;
- the page-crossing arithmetic, which is swept over lengths and offsets at and around 4096;
- the stall threshold and arrival order while the queue fills and drains.

// File: rtl/rma_cmd_ingress.sv
module rma_cmd_ingress #(
  parameter int NODE_W   = 4,
  parameter int CTX_W    = 3,
  parameter int DEPTH    = 8,
  parameter int INFLIGHT = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [15+2*CTX_W+NODE_W-1:0]  wr_off,
  input  logic [127:0]                  wr_data,
  output logic                          stall,
  output logic                          err_flag,
  output logic                          cmd_valid,
  input  logic                          cmd_ready,
  output logic [8:0]                    cmd_op,
  output logic [NODE_W-1:0]             cmd_node,
  output logic [CTX_W-1:0]              cmd_dctx,
  output logic [CTX_W-1:0]              cmd_sctx,
  output logic [127:0]                  cmd_operand
);
  localparam int SCTX_LSB = 15;
  localparam int DCTX_LSB = SCTX_LSB + CTX_W;
  localparam int NODE_LSB = DCTX_LSB + CTX_W;
  localparam int ENT_W    = 9 + NODE_W + 2*CTX_W + 128;
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] STALL_AT = CNT_W'(DEPTH - INFLIGHT);
  localparam logic [13:0]      PAGE     = 14'd4096;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] count;
  logic             err_q;

  wire [2:0]  code     = wr_off[6:4];
  wire [8:0]  opc      = {wr_off[14:12], wr_off[9:7], code};
  wire        rsvd_bad = |{wr_off[11:10], wr_off[3:0]};
  wire        code_bad = (code == 3'd7);
  wire [13:0] xlen     = {1'b0, wr_data[60:48]};
  wire [13:0] s_end    = {2'b00, wr_data[11:0]} + xlen;
  wire [13:0] d_end    = {2'b00, wr_data[75:64]} + xlen;
  wire        len_bad  = ~code[2] & ((s_end > PAGE) | (d_end > PAGE));
  wire        full     = (count == FULL_CNT);
  wire        pop      = cmd_valid & cmd_ready;
  wire        accept   = wr_en & ~rsvd_bad & ~code_bad & ~len_bad & ~full;
  wire        reject   = wr_en & ~accept;

  wire [ENT_W-1:0] entry = {opc, wr_off[NODE_LSB +: NODE_W], wr_off[DCTX_LSB +: CTX_W],
                            wr_off[SCTX_LSB +: CTX_W], wr_data};

  always_ff @(posedge clk)
    if (accept) mem[wp] <= entry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      err_q <= 1'b0;
    end else begin
      if (accept) wp <= (wp == PTR_W'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)    rp <= (rp == PTR_W'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (reject) err_q <= 1'b1;
    end
  end

  assign cmd_valid = (count != '0);
  assign stall     = (count > STALL_AT);
  assign err_flag  = err_q;
  assign {cmd_op, cmd_node, cmd_dctx, cmd_sctx, cmd_operand} = mem[rp];

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R3
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off[6:4] == 3'd7) |=> err_flag);

  // R7
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT) |-> stall);

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT && wr_en && !cmd_ready) |=> (count == FULL_CNT && err_flag));

  // R6
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !wr_en) |=> (count == $past(count) - 1'b1));
endmodule

// File: tb/rma_cmd_ingress_test.sv
module rma_cmd_ingress_test;
  localparam int NODE_W = 4;
  localparam int CTX_W  = 3;
  localparam int DEPTH  = 8;
  localparam int INFL   = 3;
  localparam int OFF_W  = 15 + 2*CTX_W + NODE_W;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, cmd_ready = 0;
  logic [OFF_W-1:0] wr_off = '0;
  logic [127:0] wr_data = '0;
  logic stall, err_flag, cmd_valid;
  logic [8:0] cmd_op;
  logic [NODE_W-1:0] cmd_node;
  logic [CTX_W-1:0] cmd_dctx, cmd_sctx;
  logic [127:0] cmd_operand;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rma_cmd_ingress #(.NODE_W(NODE_W), .CTX_W(CTX_W), .DEPTH(DEPTH), .INFLIGHT(INFL)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .stall(stall), .err_flag(err_flag), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_node(cmd_node), .cmd_dctx(cmd_dctx), .cmd_sctx(cmd_sctx),
    .cmd_operand(cmd_operand));

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [OFF_W-1:0] mk_off(input int node, input int dctx, input int sctx,
                                               input int flg, input int ntf, input int code);
    logic [OFF_W-1:0] o;
    o = '0;
    o[6:4]   = code[2:0];
    o[9:7]   = ntf[2:0];
    o[14:12] = flg[2:0];
    o[15 +: CTX_W]         = sctx[CTX_W-1:0];
    o[15+CTX_W +: CTX_W]   = dctx[CTX_W-1:0];
    o[15+2*CTX_W +: NODE_W] = node[NODE_W-1:0];
    return o;
  endfunction

  function automatic logic [127:0] mk_data(input int len, input int soff, input int doff, input int tag);
    logic [63:0] s, d;
    s = {3'b000, len[12:0], 4'h0, tag[31:0], soff[11:0]};
    d = {16'h0, 4'h5, ~tag[31:0], doff[11:0]};
    return {d, s};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0; cmd_ready = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic post(input logic [OFF_W-1:0] o, input logic [127:0] d);
    @(negedge clk); wr_en = 1; wr_off = o; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic take();
    cmd_ready = 1;
    @(negedge clk); cmd_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    check(cmd_valid == 0, "R9 valid", 128'(cmd_valid), 0);
    check(err_flag == 0, "R9 err", 128'(err_flag), 0);
    check(stall == 0, "R9 stall", 128'(stall), 0);

    // R1 R2 field sweep over every node and context value
    for (int n = 0; n < (1 << NODE_W); n++)
      for (int dc = 0; dc < (1 << CTX_W); dc++)
        for (int sc = 0; sc < (1 << CTX_W); sc++) begin
          int code = (n + dc + sc) % 7;
          int flg  = (n ^ sc) & 7;
          int ntf  = dc & 7;
          logic [127:0] d = mk_data(16, 0, 0, n*64 + dc*8 + sc);
          post(mk_off(n, dc, sc, flg, ntf, code), d);
          check(cmd_valid == 1, "R1 accepted", 128'(cmd_valid), 1);
          check(cmd_node == NODE_W'(n), "R1 node", 128'(cmd_node), 128'(n));
          check(cmd_dctx == CTX_W'(dc), "R1 dctx", 128'(cmd_dctx), 128'(dc));
          check(cmd_sctx == CTX_W'(sc), "R1 sctx", 128'(cmd_sctx), 128'(sc));
          check(cmd_op == 9'(flg*64 + ntf*8 + code), "R2 opcode", 128'(cmd_op), 128'(flg*64 + ntf*8 + code));
          check(cmd_operand == d, "R2 operand", cmd_operand, d);
          take();
          check(cmd_valid == 0, "R6 single entry", 128'(cmd_valid), 0);
        end
    check(err_flag == 0, "R9 no error on legal sweep", 128'(err_flag), 0);

    // R4 R5 length and page boundary sweep
    for (int code = 0; code < 7; code++)
      for (int li = 0; li < 6; li++)
        for (int si = 0; si < 4; si++)
          for (int di = 0; di < 2; di++) begin
            int lens[6] = '{0, 8, 4095, 4096, 4097, 8191};
            int soffs[4] = '{0, 8, 4088, 4095};
            int doffs[2] = '{0, 2048};
            int len = lens[li], so = soffs[si], dof = doffs[di];
            bit exp_ok = (code >= 4) || ((so + len <= 4096) && (dof + len <= 4096));
            logic [127:0] d = mk_data(len, so, dof, code*100 + li);
            post(mk_off(1, 2, 3, 0, 0, code), d);
            if (exp_ok) begin
              check(cmd_valid == 1, code >= 4 ? "R5 accept" : "R4 accept", 128'(cmd_valid), 1);
              check(cmd_operand == d, "R5 operand", cmd_operand, d);
              check(err_flag == 0, "R4 no error", 128'(err_flag), 0);
              take();
            end else begin
              check(cmd_valid == 0, "R4 dropped", 128'(cmd_valid), 0);
              check(err_flag == 1, "R4 error", 128'(err_flag), 1);
              do_reset();
            end
          end

    // R3 undefined code
    post(mk_off(2, 1, 1, 1, 1, 7), mk_data(8, 0, 0, 7));
    check(cmd_valid == 0, "R3 dropped", 128'(cmd_valid), 0);
    check(err_flag == 1, "R3 error", 128'(err_flag), 1);
    // R10 sticky: accepted write keeps error high
    post(mk_off(2, 1, 1, 0, 0, 4), mk_data(8, 0, 0, 9));
    check(cmd_valid == 1, "R10 later accept", 128'(cmd_valid), 1);
    check(err_flag == 1, "R10 sticky", 128'(err_flag), 1);
    take();
    do_reset();

    // R11 reserved offset bits
    for (int b = 0; b < 6; b++) begin
      int bit_pos = (b < 4) ? b : b + 6;
      logic [OFF_W-1:0] o = mk_off(3, 3, 3, 0, 0, 4);
      o[bit_pos] = 1'b1;
      post(o, mk_data(8, 0, 0, b));
      check(cmd_valid == 0, "R11 dropped", 128'(cmd_valid), 0);
      check(err_flag == 1, "R11 error", 128'(err_flag), 1);
      do_reset();
    end

    // R7 R6 R8 fill, overflow and drain
    for (int i = 0; i < DEPTH; i++) begin
      post(mk_off(i % 16, 0, 0, 0, 0, 4), 128'(i + 1000));
      check(stall == (i + 1 > DEPTH - INFL), "R7 stall filling", 128'(stall), 128'(i + 1 > DEPTH - INFL));
    end
    post(mk_off(5, 0, 0, 0, 0, 4), 128'(77));
    check(err_flag == 1, "R8 overflow error", 128'(err_flag), 1);
    check(stall == 1, "R8 still full", 128'(stall), 1);
    for (int i = 0; i < DEPTH; i++) begin
      check(cmd_operand == 128'(i + 1000), "R6 order", cmd_operand, 128'(i + 1000));
      take();
      check(stall == (DEPTH - 1 - i > DEPTH - INFL), "R7 stall draining", 128'(stall),
            128'(DEPTH - 1 - i > DEPTH - INFL));
    end
    check(cmd_valid == 0, "R8 overflow not queued", 128'(cmd_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule